// File: doc/BRIEF.md
# UART Control and Status Register Block

This block is the processor-facing side of a simple UART. A bus master issues single-word register accesses; the block decodes them, keeps the control and status registers, and drives one level-sensitive interrupt line. The bit-serial shifter, the baud clock, any FIFOs and the modem pins are not part of it. The character datapath reaches the block through two valid/ready streams instead.

The outgoing stream carries one character at a time. A write to the data register stores the character, already cut to the programmed word length, and offers it on `tx_valid`/`tx_data`. The offer stays up, with data held steady, until the consumer raises `tx_ready`. The cycle in which both are high is the transfer, and it also counts as "transmission complete". While a character waits, further data-register writes are dropped, so the stream never changes under back-pressure. The incoming stream is accepted only while the receive holding slot is empty (`rx_ready` is the inverse of the data-ready status bit). An accepted character waits in the slot until software reads the data register. If a transmit completion and a receive acceptance fall in the same cycle, the identification register ends at the receive code.

Bus accesses take one cycle. `bus_ack` and, for reads, `bus_rdata` appear in the cycle after the request. `bus_err` marks an access to an unmapped or misaligned address in that same cycle.

Top module: `uart_regif`

## Requirements
- R1: After reset the status register (offset 0x14) reads 0x20, the other registers read 0x00, and `irq`, `tx_valid` and `bus_err` are low.
- R2: Registers sit at byte offsets 0x00 (data), 0x04 (interrupt enable), 0x08 (identification), 0x0C (line control), 0x10 (modem control), 0x14 (status), 0x18 (modem status) and 0x1C (divisor). Each holds 8 bits in `bus_rdata[7:0]`, and `bus_rdata[31:8]` reads zero. Offsets 0x04 through 0x1C read back what was last written.
- R3: `bus_ack` is high, and a read's `bus_rdata` is valid, in the cycle after the cycle in which `bus_sel` was high.
- R4: An accepted write to offset 0x00 clears status bit 5 and identification bit 1, and raises `tx_valid` in the cycle after the write.
- R5: The offered character is the written byte masked by line-control bits [1:0]: 00 gives 0x1F, 01 gives 0x3F, 10 gives 0x7F, 11 gives 0xFF.
- R6: While `tx_valid` is high and `tx_ready` is low, `tx_valid` and `tx_data` hold, and writes to offset 0x00 are ignored.
- R7: On a transfer (`tx_valid` and `tx_ready` high), the identification register becomes exactly 0x02 and status bit 5 is set. `irq` rises if enable bit 1 is set. `tx_valid` drops in the next cycle unless a new character is loaded.
- R8: Writing the enable register with bit 1 set while status bit 5 is set sets identification bit 1 and raises `irq` in the next cycle. Writing it with bit 1 clear lowers `irq`. Writing it with bit 1 set while status bit 5 is clear leaves `irq` unchanged.
- R9: `rx_ready` is high exactly when status bit 0 is clear. An accepted character sets status bit 0 and sets the identification register to 0x04. It raises `irq` if enable bit 0 is set.
- R10: Reading offset 0x00 returns the held received character and clears status bit 0.
- R11: An access whose offset is misaligned or above 0x1C changes no register, reads as zero, and raises `bus_err` together with `bus_ack` for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address within the block |
| bus_wdata | input | BUS_W | Write data, low byte used |
| bus_rdata | output | BUS_W | Read data, valid with bus_ack |
| bus_ack | output | 1 | Access completed, one cycle after bus_sel |
| bus_err | output | 1 | Access hit an unmapped or misaligned address |
| irq | output | 1 | Level interrupt |
| tx_valid | output | 1 | Outgoing character offered |
| tx_data | output | 8 | Outgoing character, masked to word length |
| tx_ready | input | 1 | Consumer takes the character / transmission done |
| rx_valid | input | 1 | Incoming character offered |
| rx_data | input | 8 | Incoming character |
| rx_ready | output | 1 | Receive holding slot empty |

## Verification
Every bus result is due one cycle after the request. Register side effects of an access, such as status, identification and `irq`, are also visible from that cycle, and `tx_valid` rises in that same cycle after a data write. The bench applies requests at a falling edge, lets exactly one rising edge pass, and samples at the next falling edge. Stream effects (`irq`, status, `rx_ready`) are checked one falling edge after the rising edge that completed the handshake. A blocked receive character is checked for acceptance only one edge after the read that frees the slot.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;

  localparam int REG_W   = 8;
  localparam int REG_CNT = 8;
  localparam int IDX_W   = $clog2(REG_CNT);

  // register index = byte offset / 4
  typedef enum logic [IDX_W-1:0] {
    RG_DATA  = 3'd0,
    RG_IEN   = 3'd1,
    RG_IID   = 3'd2,
    RG_LCTL  = 3'd3,
    RG_MCTL  = 3'd4,
    RG_LSTAT = 3'd5,
    RG_MSTAT = 3'd6,
    RG_DIV   = 3'd7
  } reg_idx_e;

  localparam int IEN_RX_BIT  = 0;
  localparam int IEN_TX_BIT  = 1;
  localparam int LS_DR_BIT   = 0;
  localparam int LS_THRE_BIT = 5;
  localparam int IID_TX_BIT  = 1;

  localparam logic [REG_W-1:0] IID_TX_CODE = 8'h02;
  localparam logic [REG_W-1:0] IID_RX_CODE = 8'h04;
  localparam logic [REG_W-1:0] LS_RESET    = 8'h20;

  // word-length select -> character mask (5..8 bits)
  function automatic logic [REG_W-1:0] wls_mask(input logic [1:0] wls);
    return 8'hFF >> (2'd3 - wls);
  endfunction

endpackage

// File: rtl/uart_regif_decode.sv
module uart_regif_decode
  import uart_regif_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic               hit,
  output logic [REG_CNT-1:0] sel_oh
);
  localparam int WIDX_W = ADDR_W - 2;

  logic              aligned;
  logic [WIDX_W-1:0] word_idx;

  assign aligned  = (addr[1:0] == 2'b00);
  assign word_idx = addr[ADDR_W-1:2];
  assign hit      = aligned && (word_idx < WIDX_W'(REG_CNT));

  for (genvar i = 0; i < REG_CNT; i++) begin : g_sel
    assign sel_oh[i] = hit && (word_idx == WIDX_W'(i));
  end

endmodule

// File: rtl/uart_regif_tx.sv
module uart_regif_tx
  import uart_regif_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [REG_W-1:0] load_char,
  input  logic [1:0]       wls,
  output logic             pending,
  output logic             done,
  output logic             tx_valid,
  output logic [REG_W-1:0] tx_data,
  input  logic             tx_ready
);
  logic             pend_q;
  logic [REG_W-1:0] char_q;

  assign pending  = pend_q;
  assign tx_valid = pend_q;
  assign tx_data  = char_q;
  assign done     = pend_q && tx_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      char_q <= '0;
    end else if (load && !pend_q) begin
      pend_q <= 1'b1;
      char_q <= load_char & wls_mask(wls);
    end else if (done) begin
      pend_q <= 1'b0;
    end
  end

endmodule

// File: rtl/uart_regif_rx.sv
module uart_regif_rx
  import uart_regif_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slot_full,
  input  logic             rx_valid,
  input  logic [REG_W-1:0] rx_data,
  output logic             rx_ready,
  output logic             accept,
  output logic [REG_W-1:0] held_char
);
  logic [REG_W-1:0] char_q;

  assign rx_ready  = !slot_full;
  assign accept    = rx_valid && !slot_full;
  assign held_char = char_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      char_q <= '0;
    else if (accept) char_q <= rx_data;
  end

endmodule

// File: rtl/uart_regif.sv
module uart_regif
  import uart_regif_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BUS_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              bus_ack,
  output logic              bus_err,
  output logic              irq,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  input  logic              tx_ready,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              rx_ready
);
  logic               hit;
  logic [REG_CNT-1:0] sel_oh, wr_oh, rd_oh;
  logic [REG_W-1:0]   wbyte, rmux, rbr_char;
  logic               tx_pend, tx_done, rx_acc;
  logic               unused_wdata_hi;

  logic [REG_W-1:0] ier_q, iid_q, lctl_q, mctl_q, lsr_q, msr_q, div_q;
  logic             irq_q;

  assign wbyte           = bus_wdata[REG_W-1:0];
  assign unused_wdata_hi = ^bus_wdata[BUS_W-1:REG_W];
  assign wr_oh           = sel_oh & {REG_CNT{bus_sel &&  bus_we}};
  assign rd_oh           = sel_oh & {REG_CNT{bus_sel && !bus_we}};

  uart_regif_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr   (bus_addr),
    .hit    (hit),
    .sel_oh (sel_oh)
  );

  uart_regif_tx u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (wr_oh[RG_DATA]),
    .load_char (wbyte),
    .wls       (lctl_q[1:0]),
    .pending   (tx_pend),
    .done      (tx_done),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .tx_ready  (tx_ready)
  );

  uart_regif_rx u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .slot_full (lsr_q[LS_DR_BIT]),
    .rx_valid  (rx_valid),
    .rx_data   (rx_data),
    .rx_ready  (rx_ready),
    .accept    (rx_acc),
    .held_char (rbr_char)
  );

  // register state; stream events are applied after bus writes and win
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ier_q  <= '0;
      iid_q  <= '0;
      lctl_q <= '0;
      mctl_q <= '0;
      lsr_q  <= LS_RESET;
      msr_q  <= '0;
      div_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (wr_oh[RG_DATA] && !tx_pend) begin
        lsr_q[LS_THRE_BIT] <= 1'b0;
        iid_q[IID_TX_BIT]  <= 1'b0;
      end
      if (wr_oh[RG_IEN]) begin
        ier_q <= wbyte;
        if (wbyte[IEN_TX_BIT] && lsr_q[LS_THRE_BIT]) begin
          iid_q[IID_TX_BIT] <= 1'b1;
          irq_q             <= 1'b1;
        end else if (!wbyte[IEN_TX_BIT]) begin
          irq_q <= 1'b0;
        end
      end
      if (wr_oh[RG_IID])   iid_q  <= wbyte;
      if (wr_oh[RG_LCTL])  lctl_q <= wbyte;
      if (wr_oh[RG_MCTL])  mctl_q <= wbyte;
      if (wr_oh[RG_LSTAT]) lsr_q  <= wbyte;
      if (wr_oh[RG_MSTAT]) msr_q  <= wbyte;
      if (wr_oh[RG_DIV])   div_q  <= wbyte;
      if (rd_oh[RG_DATA])  lsr_q[LS_DR_BIT] <= 1'b0;
      if (tx_done) begin
        iid_q              <= IID_TX_CODE;
        lsr_q[LS_THRE_BIT] <= 1'b1;
        if (ier_q[IEN_TX_BIT]) irq_q <= 1'b1;
      end
      if (rx_acc) begin
        iid_q            <= IID_RX_CODE;
        lsr_q[LS_DR_BIT] <= 1'b1;
        if (ier_q[IEN_RX_BIT]) irq_q <= 1'b1;
      end
    end
  end

  always_comb begin
    rmux = '0;
    unique case (1'b1)
      sel_oh[RG_DATA]:  rmux = rbr_char;
      sel_oh[RG_IEN]:   rmux = ier_q;
      sel_oh[RG_IID]:   rmux = iid_q;
      sel_oh[RG_LCTL]:  rmux = lctl_q;
      sel_oh[RG_MCTL]:  rmux = mctl_q;
      sel_oh[RG_LSTAT]: rmux = lsr_q;
      sel_oh[RG_MSTAT]: rmux = msr_q;
      sel_oh[RG_DIV]:   rmux = div_q;
      default:          rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      bus_ack   <= 1'b0;
      bus_err   <= 1'b0;
    end else begin
      bus_ack <= bus_sel;
      bus_err <= bus_sel && !hit;
      if (bus_sel && !bus_we) bus_rdata <= {{(BUS_W-REG_W){1'b0}}, rmux};
    end
  end

  assign irq = irq_q;

endmodule

// File: rtl/uart_regif_chk.sv
module uart_regif_chk #(
  parameter int ADDR_W = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_sel,
  input logic       bus_we,
  input logic       hit_wr_data,
  input logic       bus_ack,
  input logic       bus_err,
  input logic       tx_valid,
  input logic [7:0] tx_data,
  input logic       tx_ready,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic [7:0] lsr_q
);
  p_ack_next_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel |=> bus_ack);

  p_err_with_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> bus_ack);

  p_tx_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  p_tx_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_wr_data && !tx_valid) |=> (tx_valid && !lsr_q[5]));

  p_tx_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> lsr_q[5]);

  p_rx_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready) |=> (!rx_ready && lsr_q[0]));

endmodule

bind uart_regif uart_regif_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_sel     (bus_sel),
  .bus_we      (bus_we),
  .hit_wr_data (wr_oh[0]),
  .bus_ack     (bus_ack),
  .bus_err     (bus_err),
  .tx_valid    (tx_valid),
  .tx_data     (tx_data),
  .tx_ready    (tx_ready),
  .rx_valid    (rx_valid),
  .rx_ready    (rx_ready),
  .lsr_q       (lsr_q)
);

// File: tb/uart_regif_tb.sv
`timescale 1ns/1ps
module uart_regif_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_ack, bus_err, irq, tx_valid, rx_ready;
  logic [7:0]  tx_data;
  logic        tx_ready = 1'b0, rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  uart_regif u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ack(bus_ack), .bus_err(bus_err), .irq(irq),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // request at a falling edge, one rising edge, results at the next falling edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
    chk(bus_ack === 1'b1, "R3 write ack", 32'(bus_ack), 32'd1);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] v;
    rd(a, v);
    chk(v === exp, tag, v, exp);
  endtask

  task automatic tx_finish();
    @(negedge clk); tx_ready = 1'b1;
    @(negedge clk); tx_ready = 1'b0;
  endtask

  task automatic t_reset();
    chk(irq === 1'b0 && tx_valid === 1'b0 && bus_err === 1'b0, "R1 reset pins",
        {29'd0, irq, tx_valid, bus_err}, 32'd0);
    rd_chk(8'h00, 32'h00, "R1 data reset");
    rd_chk(8'h04, 32'h00, "R1 ien reset");
    rd_chk(8'h08, 32'h00, "R1 iid reset");
    rd_chk(8'h0C, 32'h00, "R1 lctl reset");
    rd_chk(8'h10, 32'h00, "R1 mctl reset");
    rd_chk(8'h14, 32'h20, "R1 status reset");
    rd_chk(8'h18, 32'h00, "R1 mstat reset");
    rd_chk(8'h1C, 32'h00, "R1 div reset");
  endtask

  task automatic t_regs();
    for (int i = 2; i <= 7; i++) begin
      logic [7:0] pat;
      pat = 8'h5A ^ 8'(i * 17);
      if (i == 5) pat = 8'h20;  // keep status sane
      wr(8'(i * 4), {24'hABCDEF, pat});
      rd_chk(8'(i * 4), {24'd0, pat}, "R2 readback upper zero");
    end
    wr(8'h08, 32'h0); wr(8'h0C, 32'h3);
    wr(8'h04, 32'h0);
    rd_chk(8'h04, 32'h0, "R2 ien readback");
  endtask

  task automatic t_lengths();
    for (int w = 0; w < 4; w++) begin
      logic [7:0] m;
      m = (w == 0) ? 8'h1F : (w == 1) ? 8'h3F : (w == 2) ? 8'h7F : 8'hFF;
      wr(8'h0C, 32'(w));
      wr(8'h00, 32'hFF);
      chk(tx_valid === 1'b1, "R4 valid after write", 32'(tx_valid), 32'd1);
      chk(tx_data === m, "R5 masked char", 32'(tx_data), 32'(m));
      rd_chk(8'h14, 32'h00, "R4 status empty bit clear");
      tx_finish();
    end
  endtask

  task automatic t_backpressure();
    wr(8'h0C, 32'h3);
    wr(8'h00, 32'hA5);
    repeat (3) @(negedge clk);
    chk(tx_valid === 1'b1 && tx_data === 8'hA5, "R6 held", 32'(tx_data), 32'hA5);
    wr(8'h00, 32'h11);
    chk(tx_data === 8'hA5, "R6 write ignored while pending", 32'(tx_data), 32'hA5);
    tx_finish();
    chk(tx_valid === 1'b0, "R7 valid drops", 32'(tx_valid), 32'd0);
    rd_chk(8'h14, 32'h20, "R7 status empty set");
    rd_chk(8'h08, 32'h02, "R7 iid tx code");
  endtask

  task automatic t_irq();
    wr(8'h04, 32'h0);
    chk(irq === 1'b0, "R8 disable lowers irq", 32'(irq), 32'd0);
    wr(8'h00, 32'h41);
    rd_chk(8'h08, 32'h00, "R4 iid bit1 cleared");
    wr(8'h04, 32'h2);
    chk(irq === 1'b0, "R8 enable while busy no irq", 32'(irq), 32'd0);
    tx_finish();
    chk(irq === 1'b1, "R7 irq on completion", 32'(irq), 32'd1);
    wr(8'h04, 32'h0);
    chk(irq === 1'b0, "R8 irq lowered", 32'(irq), 32'd0);
    wr(8'h08, 32'h0);
    wr(8'h04, 32'h2);
    chk(irq === 1'b1, "R8 immediate irq", 32'(irq), 32'd1);
    rd_chk(8'h08, 32'h02, "R8 iid bit1 set");
    wr(8'h04, 32'h0);
  endtask

  task automatic t_rx();
    wr(8'h04, 32'h1);
    @(negedge clk);
    chk(rx_ready === 1'b1, "R9 ready when empty", 32'(rx_ready), 32'd1);
    rx_valid = 1'b1; rx_data = 8'h5A;
    @(negedge clk);
    rx_data = 8'h33;
    chk(rx_ready === 1'b0, "R9 blocked when full", 32'(rx_ready), 32'd0);
    chk(irq === 1'b1, "R9 rx irq", 32'(irq), 32'd1);
    rd_chk(8'h14, 32'h21, "R9 status ready bit");
    rd_chk(8'h08, 32'h04, "R9 iid rx code");
    rd_chk(8'h00, 32'h5A, "R10 first char");
    @(negedge clk);
    rx_valid = 1'b0;
    rd_chk(8'h00, 32'h33, "R10 second char after slot freed");
    rd_chk(8'h14, 32'h20, "R10 ready bit cleared");
    wr(8'h04, 32'h0);
  endtask

  task automatic t_bad();
    wr(8'h20, 32'h77);
    chk(bus_err === 1'b1, "R11 err unmapped write", 32'(bus_err), 32'd1);
    wr(8'h0D, 32'h00);
    chk(bus_err === 1'b1, "R11 err misaligned write", 32'(bus_err), 32'd1);
    rd_chk(8'h0C, 32'h03, "R11 lctl untouched");
    chk(bus_err === 1'b0, "R11 no err on good access", 32'(bus_err), 32'd0);
    rd_chk(8'h24, 32'h0, "R11 unmapped read zero");
    chk(bus_err === 1'b1, "R11 err unmapped read", 32'(bus_err), 32'd1);
    @(negedge clk);
    chk(bus_err === 1'b0, "R11 err one cycle", 32'(bus_err), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_lengths();
    t_backpressure();
    t_irq();
    t_rx();
    t_bad();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog (all requirements) actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

endmodule